// File: doc/BRIEF.md
# Multi-Segment Instruction Buffer Array

This block feeds instructions to a processor front end from a small set of independent buffers, each holding one contiguous, aligned block of instruction words. Every buffer carries a base register that records which aligned block it holds. On each fetch the program counter's block part is compared against every base register at once. When one matches, the low bits of the program counter pick the word inside that buffer.

A fetch that hits the buffer already in use returns its word in the same cycle. A fetch that hits a different buffer costs a fixed switch delay before the word is delivered. A fetch that misses every buffer requests the whole aligned block from memory in one wide transfer and writes it into the buffer that was filled longest ago, chosen by a rotating pointer. That buffer then becomes the one in use. The fetch side holds its request and program counter steady until the valid output rises.

Top module: `iseg_buffer`

## Requirements
- R1: After reset every buffer is empty, the rotation pointer and the in-use buffer are buffer 0, and `instr_valid` and `mem_req` are low.
- R2: A fetch that matches no buffer raises `mem_req` with `mem_addr` equal to the program counter with its low log2(SEG_WORDS) bits cleared. It holds both steady until `mem_done`, and delivers the word in the cycle after the one in which `mem_done` is seen.
- R3: A fetch that matches the buffer in use raises `instr_valid` in the same cycle, with no memory request.
- R4: A fetch that matches a valid buffer other than the one in use raises `instr_valid` exactly SWITCH_DLY cycles after the request appears, with no memory request. That buffer then becomes the one in use.
- R5: The delivered word is the word at offset `fetch_pc[log2(SEG_WORDS)-1:0]` of the matching block. Word i of a fill lies at `mem_data[i*WORD_W +: WORD_W]`.
- R6: Fills go to buffers 0, 1, 2, ... in strict rotation, wrapping after NUM_SEG-1. The buffer replaced is always the one filled longest ago, whichever buffers were used in between.
- R7: `instr_valid` stays low while a fill or a switch delay is in progress.
- R8: Up to NUM_SEG distinct blocks stay mapped at the same time, and no program counter ever matches more than one buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request, held until `instr_valid` |
| fetch_pc | input | ADDR_W | Word address of the fetch |
| instr | output | WORD_W | Fetched instruction word |
| instr_valid | output | 1 | `instr` is valid for `fetch_pc` |
| mem_req | output | 1 | Block fill request to memory |
| mem_addr | output | ADDR_W | Aligned word address of the block to fill |
| mem_done | input | 1 | Memory has placed the block on `mem_data` |
| mem_data | input | SEG_WORDS*WORD_W | Whole block, word 0 in the low bits |

## Verification
Each result has a fixed due cycle, counted from the cycle the request is driven. A hit in the buffer in use is due at cycle 0. A hit in another buffer is due at cycle SWITCH_DLY. A miss is due at the memory model's latency plus 2: one cycle to enter the fill state and one to leave it after `mem_done`. The bench drives each fetch just after a falling edge and samples one time unit later on every later falling edge, counting edges until `instr_valid`. It compares that count with the due cycle worked out from the requirements, and compares the word with the value its own memory formula gives for that address. Fills are counted at the port, so every hit must leave the count unchanged and every miss must add exactly one.

// File: rtl/iseg_buffer.sv
module iseg_buffer #(
  parameter int NUM_SEG    = 4,
  parameter int SEG_WORDS  = 64,
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 16,
  parameter int SWITCH_DLY = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fetch_req,
  input  logic [ADDR_W-1:0]           fetch_pc,
  output logic [WORD_W-1:0]           instr,
  output logic                        instr_valid,
  output logic                        mem_req,
  output logic [ADDR_W-1:0]           mem_addr,
  input  logic                        mem_done,
  input  logic [SEG_WORDS*WORD_W-1:0] mem_data
);
  localparam int OFS_W = $clog2(SEG_WORDS);
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam int IDX_W = $clog2(NUM_SEG);
  localparam int CNT_W = $clog2(SWITCH_DLY + 1);

  typedef enum logic [1:0] {ST_READY, ST_SWITCH, ST_FILL} st_t;

  st_t               st;
  logic [WORD_W-1:0] words [NUM_SEG][SEG_WORDS];
  logic [TAG_W-1:0]  base  [NUM_SEG];
  logic [NUM_SEG-1:0] live;
  logic [IDX_W-1:0]  cur, victim, hit_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic [CNT_W-1:0]  wait_cnt;
  logic [NUM_SEG-1:0] hit_vec;

  wire [TAG_W-1:0] pc_tag = fetch_pc[ADDR_W-1:OFS_W];
  wire [OFS_W-1:0] pc_ofs = fetch_pc[OFS_W-1:0];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_cmp
    assign hit_vec[g] = live[g] && (base[g] == pc_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_SEG; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  wire any_hit = |hit_vec;

  assign instr       = words[cur][pc_ofs];
  assign instr_valid = (st == ST_READY) && fetch_req && any_hit && (hit_idx == cur);
  assign mem_req     = (st == ST_FILL);
  assign mem_addr    = {fill_tag, {OFS_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_READY;
      live     <= '0;
      cur      <= '0;
      victim   <= '0;
      fill_tag <= '0;
      wait_cnt <= '0;
    end else begin
      case (st)
        ST_READY: if (fetch_req) begin
          if (!any_hit) begin
            fill_tag <= pc_tag;
            st       <= ST_FILL;
          end else if (hit_idx != cur) begin
            cur      <= hit_idx;
            wait_cnt <= CNT_W'(SWITCH_DLY - 1);
            st       <= ST_SWITCH;
          end
        end
        ST_SWITCH: begin
          if (wait_cnt <= CNT_W'(1)) st <= ST_READY;
          else wait_cnt <= wait_cnt - CNT_W'(1);
        end
        ST_FILL: if (mem_done) begin
          live[victim] <= 1'b1;
          cur          <= victim;
          victim       <= victim + IDX_W'(1);
          st           <= ST_READY;
        end
        default: st <= ST_READY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == ST_FILL && mem_done) begin
      base[victim] <= fill_tag;
      for (int w = 0; w < SEG_WORDS; w++)
        words[victim][w] <= mem_data[w*WORD_W +: WORD_W];
    end
  end

  a_r7_quiet_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !instr_valid);

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr)));

  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r6_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_done) |=> (victim == IDX_W'($past(victim) + IDX_W'(1))));

  a_r4_switch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SWITCH) |-> (!instr_valid && !mem_req));

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!mem_req && !instr_valid));
endmodule

// File: tb/iseg_buffer_test.sv
`timescale 1ns/1ps
module iseg_buffer_test;
  localparam int NS = 4, SW = 64, WW = 16, AW = 16, SDLY = 2, LAT = 4;
  localparam int MISS_LAT = LAT + 2;

  logic clk = 0, rst_n = 0, fetch_req = 0, mem_done = 0;
  logic [AW-1:0] fetch_pc = '0;
  logic [WW-1:0] instr;
  logic instr_valid, mem_req;
  logic [AW-1:0] mem_addr, last_addr = '0;
  logic [SW*WW-1:0] mem_data;
  int checks = 0, errors = 0, fills = 0, overlap = 0, lat_cnt = 0;

  always #5 clk = ~clk;

  iseg_buffer #(.NUM_SEG(NS), .SEG_WORDS(SW), .WORD_W(WW), .ADDR_W(AW), .SWITCH_DLY(SDLY)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .instr(instr), .instr_valid(instr_valid), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_done(mem_done), .mem_data(mem_data));

  function automatic logic [WW-1:0] pattern(input logic [AW-1:0] a);
    logic [31:0] p = 32'(a) * 32'd40503;
    return p[WW-1:0] ^ 16'h3C96;
  endfunction

  always_comb
    for (int i = 0; i < SW; i++) mem_data[i*WW +: WW] = pattern(mem_addr + AW'(i));

  always @(posedge clk) begin
    if (mem_req && instr_valid) overlap <= overlap + 1;
    if (mem_req && mem_done) begin fills <= fills + 1; last_addr <= mem_addr; end
    if (mem_req && !mem_done) begin
      if (lat_cnt == LAT - 1) begin mem_done <= 1'b1; lat_cnt <= 0; end
      else lat_cnt <= lat_cnt + 1;
    end else mem_done <= 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [AW-1:0] pc, input int exp_lat, input string req);
    int lat = 0;
    int f0 = fills;
    @(negedge clk);
    fetch_req = 1'b1;
    fetch_pc  = pc;
    #1;
    while (!instr_valid && lat < 100) begin
      @(negedge clk); #1; lat++;
    end
    check(lat == exp_lat, req, lat, exp_lat);
    check(instr == pattern(pc), "R5 word", int'(instr), int'(pattern(pc)));
    check((fills - f0) == (exp_lat == MISS_LAT ? 1 : 0), req, fills - f0, exp_lat == MISS_LAT ? 1 : 0);
    if (exp_lat == MISS_LAT)
      check(last_addr == (pc & ~AW'(SW - 1)), "R2 addr", int'(last_addr), int'(pc & ~AW'(SW - 1)));
    fetch_req = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] b0 = 16'h0000, b1 = 16'h0400, b2 = 16'h1040, b3 = 16'h2000, b4 = 16'h3FC0;
    repeat (3) @(negedge clk);
    #1;
    check(!instr_valid && !mem_req, "R1 reset", int'(instr_valid) + int'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!instr_valid && !mem_req, "R1 idle", int'(instr_valid) + int'(mem_req), 0);
    fetch(b0 + 5, MISS_LAT, "R2 first miss");
    for (int w = 0; w < SW; w++) fetch(b0 + AW'(w), 0, "R3 same buffer sweep");
    fetch(b1 + 63, MISS_LAT, "R2 miss b1");
    fetch(b2, MISS_LAT, "R2 miss b2");
    fetch(b3 + 17, MISS_LAT, "R8 fourth block");
    fetch(b0 + 9, SDLY, "R4 switch to b0");
    fetch(b0 + 10, 0, "R3 stay b0");
    fetch(b1 + 1, SDLY, "R8 b1 still mapped");
    fetch(b2 + 33, SDLY, "R8 b2 still mapped");
    fetch(b3 + 62, SDLY, "R4 switch to b3");
    for (int w = 0; w < SW; w += 7) fetch(b3 + AW'(w), 0, "R3 b3 sweep");
    fetch(b4 + 3, MISS_LAT, "R6 fifth block evicts oldest");
    fetch(b1, SDLY, "R6 b1 kept");
    fetch(b0, MISS_LAT, "R6 b0 evicted");
    fetch(b2 + 5, SDLY, "R6 b2 kept");
    fetch(b1 + 2, MISS_LAT, "R6 b1 evicted second");
    fetch(b4 + 60, SDLY, "R6 b4 kept");
    check(overlap == 0, "R7 valid during fill", overlap, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule